// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Turnaround Idle Insertion

This block runs external memory read and write cycles for a CPU-side request port. It drives the address, an area tag, write data with its output enable, and the address, read and write strobes of a shared bidirectional data bus. A read takes three bus states (T1, T2, T3) and a write takes two (T1, T2). Requests are taken through a valid/ready handshake, either from idle or during the final state of the running cycle, so same-direction cycles can follow each other with no gap.

The sequencer keeps a record of the direction of the last external cycle. When the direction changes, it can put a single idle state (Ti) in front of the T1 of the new cycle. During Ti no strobe is active and the data drivers are off, but the address bus already shows the new address. This gives a device that is slow to release the bus, or the CPU's own write drivers, one state to leave the bus before the other side drives it. Two configuration bits choose whether the idle state is added on a read followed by a write and on a write followed by a read. Both bits are loaded together through a one-cycle strobe.

Top module: `ext_bus_seq`

## Requirements
- R1: With the write-after-read enable set, a write accepted after a read gets one idle state before its T1, so wr_ack comes 4 cycles after acceptance instead of 3.
- R2: With the read-after-write enable set, a read accepted after a write gets one idle state before its T1, so rd_valid comes 5 cycles after acceptance instead of 4.
- R3: After reset the write-after-read enable is 1 and the read-after-write enable is 0.
- R4: cfg_we loads cfg_war_en and cfg_raw_en together. The loaded values decide insertion for every cycle accepted afterwards.
- R5: A read after a read, or a write after a write, never gets an idle state.
- R6: Reset clears the previous-direction record, so the first cycle accepted after reset never gets an idle state.
- R7: During the idle state bus_as_n, bus_rd_n and bus_wr_n are 1 and bus_oe is 0, while bus_addr already holds the new request's address. The idle state is always followed by T1.
- R8: A read holds bus_as_n and bus_rd_n low for T1, T2 and T3 and keeps bus_oe at 0. bus_din is sampled at the end of T3 and returned on rd_data with a one-cycle rd_valid pulse in the following cycle.
- R9: A write drives bus_oe high with bus_dout equal to the request data during T1 and T2. It pulls bus_wr_n low for T2 only (exactly one cycle) and pulses wr_ack for one cycle after T2. bus_oe is never 1 while bus_rd_n is 0.
- R10: req_ready is 1 while the bus is idle and during the last state of a cycle. A request held during T3 of a read is accepted there, and its T1 follows T3 directly with no gap.
- R11: After reset req_ready is 1, every strobe is 1, and bus_oe, rd_valid and wr_ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for both turnaround enables |
| cfg_war_en | input | 1 | Enable idle state for write after read |
| cfg_raw_en | input | 1 | Enable idle state for read after write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | ARW | Area tag carried to the bus |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | DW | Read data sampled at the end of T3 |
| wr_ack | output | 1 | One-cycle pulse after a write's T2 |
| bus_addr | output | AW | External address bus |
| bus_area | output | ARW | External area tag |
| bus_dout | output | DW | Data driven onto the external bus |
| bus_din | input | DW | Data read from the external bus |
| bus_oe | output | 1 | Data bus output enable |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The main stimulus is a sequence of reads and writes in which every direction pair (read-read, read-write, write-read, write-write) appears under different settings of the two enables. Measuring the latency from acceptance to rd_valid or wr_ack tells an inserted idle state apart from a missing one, and a missing one apart from a spurious one. Reset is applied after a read and after a write, with the enables left at their reset values. This tests that the direction record is cleared and that only write-after-read insertion is on by default. A held read request that overlaps T3 of a running read checks that same-direction cycles run back to back with no gap, and that the new address appears in the cycle right after T3.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TI   = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4
  } bus_st_t;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_RD   = 2'd1,
    DIR_WR   = 2'd2
  } bus_dir_t;
endpackage

// File: rtl/ebus_turnaround.sv
module ebus_turnaround
  import ebus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_war_en,
  input  logic cfg_raw_en,
  input  logic accept,
  input  logic acc_write,
  output logic need_idle
);
  logic     war_q, raw_q;
  bus_dir_t prev_q;

  // enable bits: write-after-read on by default, read-after-write off
  always_ff @(posedge clk) begin
    if (rst) begin
      war_q <= 1'b1;
      raw_q <= 1'b0;
    end else if (cfg_we) begin
      war_q <= cfg_war_en;
      raw_q <= cfg_raw_en;
    end
  end

  // direction of the most recent accepted external cycle
  always_ff @(posedge clk) begin
    if (rst)
      prev_q <= DIR_NONE;
    else if (accept)
      prev_q <= acc_write ? DIR_WR : DIR_RD;
  end

  always_comb begin
    need_idle = 1'b0;
    if (prev_q == DIR_RD && acc_write && war_q)
      need_idle = 1'b1;
    if (prev_q == DIR_WR && !acc_write && raw_q)
      need_idle = 1'b1;
  end

  assert_cfg_load_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (war_q == $past(cfg_war_en)) && (raw_q == $past(cfg_raw_en)));

  assert_same_dir_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && (prev_q == (acc_write ? DIR_WR : DIR_RD))) |-> !need_idle);
endmodule

// File: rtl/ebus_fsm.sv
module ebus_fsm
  import ebus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int ARW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [ARW-1:0] req_area,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic           need_idle,
  output logic           req_ready,
  output logic           accept,
  output bus_st_t        st_q,
  output bus_st_t        st_nxt,
  output logic           cur_write,
  output logic           nxt_write,
  output logic [ARW-1:0] nxt_area,
  output logic [AW-1:0]  nxt_addr,
  output logic [DW-1:0]  nxt_wdata
);
  logic [ARW-1:0] cur_area;
  logic [AW-1:0]  cur_addr;
  logic [DW-1:0]  cur_wdata;
  logic           last_state;
  bus_st_t        start_st;

  assign last_state = (st_q == ST_T3) || (st_q == ST_T2 && cur_write);
  assign req_ready  = (st_q == ST_IDLE) || last_state;
  assign accept     = req_valid && req_ready;
  assign start_st   = need_idle ? ST_TI : ST_T1;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE: st_nxt = accept ? start_st : ST_IDLE;
      ST_TI:   st_nxt = ST_T1;
      ST_T1:   st_nxt = ST_T2;
      ST_T2:   st_nxt = cur_write ? (accept ? start_st : ST_IDLE) : ST_T3;
      ST_T3:   st_nxt = accept ? start_st : ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign nxt_write = accept ? req_write : cur_write;
  assign nxt_area  = accept ? req_area  : cur_area;
  assign nxt_addr  = accept ? req_addr  : cur_addr;
  assign nxt_wdata = accept ? req_wdata : cur_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cur_write <= 1'b0;
      cur_area  <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      st_q      <= st_nxt;
      cur_write <= nxt_write;
      cur_area  <= nxt_area;
      cur_addr  <= nxt_addr;
      cur_wdata <= nxt_wdata;
    end
  end

  assert_idle_then_t1_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TI) |=> (st_q == ST_T1));

  assert_read_read_direct_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T3 && accept && !req_write) |=> (st_q == ST_T1));

  assert_no_accept_mid_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T1 || st_q == ST_TI) |-> !req_ready);
endmodule

// File: rtl/ebus_pins.sv
module ebus_pins
  import ebus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int ARW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  bus_st_t        st_q,
  input  bus_st_t        st_nxt,
  input  logic           cur_write,
  input  logic           nxt_write,
  input  logic [ARW-1:0] nxt_area,
  input  logic [AW-1:0]  nxt_addr,
  input  logic [DW-1:0]  nxt_wdata,
  input  logic [DW-1:0]  bus_din,
  output logic [AW-1:0]  bus_addr,
  output logic [ARW-1:0] bus_area,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_oe,
  output logic           bus_as_n,
  output logic           bus_rd_n,
  output logic           bus_wr_n,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           wr_ack
);
  logic nxt_active;
  assign nxt_active = (st_nxt == ST_T1) || (st_nxt == ST_T2) || (st_nxt == ST_T3);

  // pins decoded from the next state so they change with the state register
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_area <= '0;
      bus_dout <= '0;
      bus_oe   <= 1'b0;
      bus_as_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
    end else begin
      bus_addr <= nxt_addr;
      bus_area <= nxt_area;
      bus_dout <= nxt_wdata;
      bus_oe   <= nxt_write && (st_nxt == ST_T1 || st_nxt == ST_T2);
      bus_as_n <= !nxt_active;
      bus_rd_n <= !(nxt_active && !nxt_write);
      bus_wr_n <= !(nxt_write && st_nxt == ST_T2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      wr_ack   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= (st_q == ST_T3);
      wr_ack   <= (st_q == ST_T2) && cur_write;
      if (st_q == ST_T3)
        rd_data <= bus_din;
    end
  end

  assert_no_drive_while_read_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_oe && !bus_rd_n));

  assert_rd_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_wr_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !wr_ack);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TI) |-> (bus_as_n && bus_rd_n && bus_wr_n && !bus_oe));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int ARW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic           cfg_war_en,
  input  logic           cfg_raw_en,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [ARW-1:0] req_area,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           wr_ack,
  output logic [AW-1:0]  bus_addr,
  output logic [ARW-1:0] bus_area,
  output logic [DW-1:0]  bus_dout,
  input  logic [DW-1:0]  bus_din,
  output logic           bus_oe,
  output logic           bus_as_n,
  output logic           bus_rd_n,
  output logic           bus_wr_n
);
  logic           accept, need_idle, cur_write, nxt_write;
  bus_st_t        st_q, st_nxt;
  logic [ARW-1:0] nxt_area;
  logic [AW-1:0]  nxt_addr;
  logic [DW-1:0]  nxt_wdata;

  ebus_turnaround u_turn (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_war_en (cfg_war_en),
    .cfg_raw_en (cfg_raw_en),
    .accept     (accept),
    .acc_write  (req_write),
    .need_idle  (need_idle)
  );

  ebus_fsm #(.AW(AW), .DW(DW), .ARW(ARW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_area  (req_area),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .need_idle (need_idle),
    .req_ready (req_ready),
    .accept    (accept),
    .st_q      (st_q),
    .st_nxt    (st_nxt),
    .cur_write (cur_write),
    .nxt_write (nxt_write),
    .nxt_area  (nxt_area),
    .nxt_addr  (nxt_addr),
    .nxt_wdata (nxt_wdata)
  );

  ebus_pins #(.AW(AW), .DW(DW), .ARW(ARW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_q      (st_q),
    .st_nxt    (st_nxt),
    .cur_write (cur_write),
    .nxt_write (nxt_write),
    .nxt_area  (nxt_area),
    .nxt_addr  (nxt_addr),
    .nxt_wdata (nxt_wdata),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_area  (bus_area),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .bus_as_n  (bus_as_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wr_ack    (wr_ack)
  );
endmodule

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'h5A5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_war_en = 1'b0, cfg_raw_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_area = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rd_valid, wr_ack, bus_oe, bus_as_n, bus_rd_n, bus_wr_n;
  logic [15:0] rd_data, bus_addr, bus_dout, bus_din;
  logic [2:0]  bus_area;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // external device model: drives a pattern derived from the address while read strobe is low
  assign bus_din = !bus_rd_n ? (bus_addr ^ KEY) : 16'h0000;

  ext_bus_seq dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_war_en(cfg_war_en), .cfg_raw_en(cfg_raw_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_area(req_area),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_ack(wr_ack), .bus_addr(bus_addr), .bus_area(bus_area), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_oe(bus_oe), .bus_as_n(bus_as_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n)
  );

  // {write, war_en, raw_en, expect_idle, addr, wdata}
  localparam logic [35:0] VEC [9] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h1111},  // first after reset: R6
    {1'b0, 1'b1, 1'b0, 1'b0, 16'h0020, 16'h0000},  // W->R, raw off
    {1'b1, 1'b1, 1'b0, 1'b1, 16'h0030, 16'h2222},  // R->W, war on: R1
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h0040, 16'h3333},  // W->W: R5
    {1'b0, 1'b1, 1'b1, 1'b1, 16'h0050, 16'h0000},  // W->R, raw on: R2 R4
    {1'b0, 1'b1, 1'b1, 1'b0, 16'h0060, 16'h0000},  // R->R: R5
    {1'b1, 1'b0, 1'b1, 1'b0, 16'h0070, 16'h4444},  // R->W, war off: R4
    {1'b0, 1'b0, 1'b1, 1'b1, 16'h0080, 16'h0000},  // W->R: R2
    {1'b1, 1'b1, 1'b1, 1'b1, 16'h0090, 16'h5555}   // R->W, war back on: R4
  };

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic check(input logic ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic war, input logic raw);
    @(negedge clk);
    cfg_we = 1'b1; cfg_war_en = war; cfg_raw_en = raw;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_op(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input logic exp_idle, input string tag);
    int k;
    int wstrobes;
    logic done;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_area = a[2:0];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    if (exp_idle) begin
      check(bus_as_n && bus_rd_n && bus_wr_n && !bus_oe, {tag, " R7 idle state quiet"},
            {28'h0, bus_as_n, bus_rd_n, bus_wr_n, bus_oe}, 32'he);
      check(bus_addr == a, {tag, " R7 address during idle"}, bus_addr, a);
    end else begin
      check(!bus_as_n, {tag, " R1 R2 R5 no idle state"}, bus_as_n, 0);
    end
    done = 1'b0;
    wstrobes = 0;
    while (!done && k < 20) begin
      if (!bus_wr_n) begin
        wstrobes++;
        check(bus_oe && bus_dout == d, {tag, " R9 data driven in T2"}, bus_dout, d);
      end
      if (wr ? wr_ack : rd_valid) done = 1'b1;
      else begin
        @(negedge clk);
        k++;
      end
    end
    check(k == (wr ? 3 : 4) + int'(exp_idle), {tag, " R1 R2 R8 R9 latency"},
          k, (wr ? 3 : 4) + int'(exp_idle));
    if (wr) check(wstrobes == 1, {tag, " R9 one write strobe"}, wstrobes, 1);
    else    check(rd_data == (a ^ KEY), {tag, " R8 read data"}, rd_data, a ^ KEY);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired: R10 run did not finish actual=0 expected=1");
    summary_and_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(req_ready && bus_as_n && bus_rd_n && bus_wr_n && !bus_oe && !rd_valid && !wr_ack,
          "R11 reset state", {25'h0, req_ready, bus_as_n, bus_rd_n, bus_wr_n, bus_oe,
          rd_valid, wr_ack}, 32'h78);

    for (int i = 0; i < 9; i++) begin
      set_cfg(VEC[i][34], VEC[i][33]);
      run_op(VEC[i][35], VEC[i][31:16], VEC[i][15:0], VEC[i][32], $sformatf("vec%0d", i));
    end

    // R6: a read before reset must be forgotten; enables at reset defaults (R3)
    do_reset();
    run_op(1'b0, 16'h00A0, 16'h0000, 1'b0, "R6 first read after reset");
    do_reset();
    run_op(1'b1, 16'h00B0, 16'h6666, 1'b0, "R6 write after reset, prior read forgotten");
    run_op(1'b0, 16'h00C0, 16'h0000, 1'b0, "R3 read-after-write off by default");
    run_op(1'b1, 16'h00D0, 16'h7777, 1'b1, "R3 write-after-read on by default");

    // R10 / R5: back-to-back reads, second accepted during T3 of the first
    set_cfg(1'b1, 1'b1);
    run_op(1'b0, 16'h00E0, 16'h0000, 1'b1, "R2 setup read");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0100; req_area = 3'd1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);                       // T1 of first read
    req_addr = 16'h0200;
    check(!req_ready, "R10 not ready in T1", req_ready, 0);
    @(negedge clk);                       // T2
    @(negedge clk);                       // T3
    check(req_ready && !bus_rd_n, "R10 ready in T3", req_ready, 1);
    @(negedge clk);                       // T1 of second read
    req_valid = 1'b0;
    check(!bus_as_n && !bus_rd_n && bus_addr == 16'h0200, "R10 R5 no gap between reads",
          bus_addr, 16'h0200);
    check(rd_valid && rd_data == (16'h0100 ^ KEY), "R8 first back-to-back data",
          rd_data, 16'h0100 ^ KEY);
    repeat (3) @(negedge clk);
    check(rd_valid && rd_data == (16'h0200 ^ KEY), "R8 second back-to-back data",
          rd_data, 16'h0200 ^ KEY);

    summary_and_end();
  end
endmodule